// File: doc/BRIEF.md
# Two-Byte Committed-Duty PWM Channel

This block is one pulse-width modulation channel with a 10-bit duty value. The value reaches it over a small 8-bit peripheral bus: a strobed write with an address, and a read strobe with combinational read data. Because the bus is only one byte wide, the duty value is split across two write-only registers. A write to the low-byte register only parks that byte in a staging latch. A later write to the high-byte register joins its two data bits to the staged byte and hands the full 10-bit value to the waveform generator as one update.

The generator uses a free-running 10-bit counter, which gives a period of 1024 clocks. The output is high for exactly as many clocks per period as the committed duty value. A new duty value is held back until the counter wraps, so no period is ever cut short. A control register holds a run bit. Clearing the run bit puts the channel in standby: the counter freezes and the output is forced low. The bus side stays live in standby, so software can prepare a new duty value before it wakes the channel.

The address map is as follows:
- Address 0: low duty byte.
- Address 1: high duty byte.
- Address 2: control register.
- Address 3: reserved.

Top module: `pwm10_staged`

## Requirements
- R1: After reset the committed duty is 0, the output is low, the run bit is 1, and a read of the control register (address 2) returns 8'hFF.
- R2: A write to address 0 only stages the byte. The duty in use, and so the output, does not change.
- R3: A write to address 1 commits the value {wdata[1:0], staged low byte} as one update. Bits 7:2 of that write are ignored.
- R4: A write to address 1 with no earlier write to address 0 since reset commits a low byte of 0.
- R5: Each period is 1024 clocks long, and the output is high for exactly the committed duty number of clocks in it. Duty 0 keeps the output constantly low, and duty 1023 leaves exactly one low clock per period.
- R6: A committed value takes effect only when the counter wraps from 1023 to 0. The period that is running completes with the old value.
- R7: Reads of address 0, 1 or 3 return 8'hFF. The read data is 8'h00 whenever the read strobe is low.
- R8: Control bit 0 is the run bit, and reads of the control register return 1 in bits 7:1. Writing 0 to the run bit enters standby: the counter holds its value and the output stays low. Writing 1 resumes the channel.
- R9: Register writes made during standby are accepted. A commit made during standby takes effect at the first wrap after the channel resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| pwm_out | output | 1 | PWM waveform |

## Verification
On every cycle, the assertions check the following:
- The duty in use changes only on the cycle after a wrap.
- The counter holds still and the output stays low in standby.
- Duty 0 never produces a high output.
- Reads of the data registers return all ones.

Other behaviours only the bench scenarios can show. These are the exact high-clock count per period for each duty value, the pairing of the staged low byte with the high-byte bits, and the fact that a write to the low byte alone leaves the waveform unchanged. They also include the completion of a running period after a mid-period commit, and a commit made in standby appearing after wake-up.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  localparam int DUTY_W = 10;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_LO  = 2'd0,
    ADR_HI  = 2'd1,
    ADR_CTL = 2'd2,
    ADR_RSV = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm10_regif.sv
module pwm10_regif
  import pwm10_pkg::*;
#(
  parameter int DW = DUTY_W,
  parameter int BW = BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  output logic              run,
  output logic              commit,
  output logic [DW-1:0]     commit_val
);
  localparam int HW = DW - BW;

  logic [BW-1:0] lo_q, lo_d;
  logic          run_q, run_d;

  // next-state logic
  always_comb begin
    lo_d       = lo_q;
    run_d      = run_q;
    commit     = 1'b0;
    commit_val = {wdata[HW-1:0], lo_q};
    if (wr) begin
      case (reg_addr_e'(addr))
        ADR_LO:  lo_d   = wdata;
        ADR_HI:  commit = 1'b1;
        ADR_CTL: run_d  = wdata[0];
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      run_q <= 1'b1;
    end else begin
      lo_q  <= lo_d;
      run_q <= run_d;
    end
  end

  // read mux: the data registers are write-only and read back as all ones
  always_comb begin
    rdata = '0;
    if (rd) begin
      if (reg_addr_e'(addr) == ADR_CTL) rdata = {{(BW-1){1'b1}}, run_q};
      else                              rdata = '1;
    end
  end

  assign run = run_q;
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          commit,
  input  logic [DW-1:0] commit_val,
  output logic          pwm_out,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] duty_o
);
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] duty_q, duty_d;
  logic [DW-1:0] pend_q, pend_d;
  logic          pend_vld_q, pend_vld_d;
  logic          wrap;

  // a wrap happens only on a cycle where the counter is enabled
  assign wrap = run && (cnt_q == CNT_MAX);

  // next-state logic
  always_comb begin
    cnt_d      = cnt_q;
    duty_d     = duty_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    if (run) cnt_d = cnt_q + 1'b1;
    if (commit) begin
      pend_d     = commit_val;
      pend_vld_d = 1'b1;
    end
    if (wrap) begin
      if (commit) begin
        duty_d     = commit_val;
        pend_vld_d = 1'b0;
      end else if (pend_vld_q) begin
        duty_d     = pend_q;
        pend_vld_d = 1'b0;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      duty_q     <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      duty_q     <= duty_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  assign pwm_out = run && (cnt_q < duty_q);
  assign cnt_o   = cnt_q;
  assign duty_o  = duty_q;
endmodule

// File: rtl/pwm10_staged.sv
module pwm10_staged
  import pwm10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              run_en;
  logic              commit;
  logic [DUTY_W-1:0] commit_val;
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] duty_act;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pwm10_regif #(.DW(DUTY_W), .BW(BUS_W)) regif_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .run        (run_en),
    .commit     (commit),
    .commit_val (commit_val)
  );

  pwm10_gen #(.DW(DUTY_W)) gen_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run_en),
    .commit     (commit),
    .commit_val (commit_val),
    .pwm_out    (pwm_out),
    .cnt_o      (cnt_q),
    .duty_o     (duty_act)
  );
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk
  import pwm10_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [DUTY_W-1:0] cnt,
  input logic [DUTY_W-1:0] duty_act,
  input logic              pwm_out,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata
);
  localparam logic [DUTY_W-1:0] CMAX = '1;

  // R6
  duty_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_act) |-> $past(run && (cnt == CMAX)));

  // R8
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> $stable(cnt));

  // R8
  standby_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pwm_out);

  // R5
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_out);

  // R7
  data_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr != ADR_CTL)) |-> (bus_rdata == 8'hFF));

  // R7
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind pwm10_staged pwm10_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .run       (run_en),
  .cnt       (cnt_q),
  .duty_act  (duty_act),
  .pwm_out   (pwm_out),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/pwm10_staged_tb_top.sv
module pwm10_staged_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pwm_out;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  pwm10_staged dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // {low byte, high byte, expected high clocks per period}
  localparam logic [25:0] VEC [6] = '{
    {8'h00, 8'h00, 10'd0},
    {8'hFF, 8'h03, 10'd1023},
    {8'h2C, 8'h01, 10'd300},
    {8'h01, 8'h00, 10'd1},
    {8'h55, 8'hFE, 10'd597},
    {8'h80, 8'h02, 10'd640}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic count_high(output int hi);
    hi = 0;
    for (int k = 0; k < 1024; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic settle_and_count(output int hi);
    repeat (2048) @(negedge clk);
    count_high(hi);
  endtask

  task automatic sync_rise();
    logic prev;
    prev = 1'b1;
    for (int k = 0; k < 4096; k++) begin
      @(negedge clk);
      if (pwm_out && !prev) return;
      prev = pwm_out;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int hi, lows;

    repeat (4) @(negedge clk);
    check("R1 pwm low in reset", pwm_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(2'd2, rd); check("R1 ctrl reset value", rd, 8'hFF);
    rd_reg(2'd0, rd); check("R7 low reads ones", rd, 8'hFF);
    rd_reg(2'd1, rd); check("R7 high reads ones", rd, 8'hFF);
    rd_reg(2'd3, rd); check("R7 reserved reads ones", rd, 8'hFF);
    @(negedge clk); check("R7 idle rdata zero", bus_rdata, 0);
    count_high(hi); check("R1 reset duty zero", hi, 0);

    // R4: high write without prior low write
    wr_reg(2'd1, 8'h01);
    settle_and_count(hi); check("R4 default low byte", hi, 256);

    // vector table: R3, R5
    for (int i = 0; i < 6; i++) begin
      logic [25:0] v;
      v = VEC[i];
      wr_reg(2'd0, v[25:18]);
      wr_reg(2'd1, v[17:10]);
      settle_and_count(hi);
      check($sformatf("R3/R5 vector %0d", i), hi, int'(v[9:0]));
    end
    rd_reg(2'd0, rd); check("R7 low reads ones after writes", rd, 8'hFF);

    // R6: mid-period commit waits for the wrap
    wr_reg(2'd0, 8'h2C); wr_reg(2'd1, 8'h01);
    repeat (2048) @(negedge clk);
    sync_rise();
    repeat (500) @(negedge clk);
    wr_reg(2'd0, 8'h20); wr_reg(2'd1, 8'h03);
    lows = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!pwm_out) lows++;
    end
    check("R6 old duty completes period", lows, 400);
    sync_rise();
    hi = 1;
    for (int k = 0; k < 1023; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    check("R6 new duty next period", hi, 800);

    // R2: low write alone has no effect
    wr_reg(2'd0, 8'hFF);
    settle_and_count(hi); check("R2 low write stages only", hi, 800);

    // R8 / R9: standby
    wr_reg(2'd2, 8'h00);
    rd_reg(2'd2, rd); check("R8 ctrl reads run cleared", rd, 8'hFE);
    count_high(hi); check("R8 output low in standby", hi, 0);
    wr_reg(2'd0, 8'h64); wr_reg(2'd1, 8'h00);
    count_high(hi); check("R9 commit in standby stays low", hi, 0);
    wr_reg(2'd2, 8'h01);
    settle_and_count(hi); check("R9 standby commit applied", hi, 100);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule